// File: doc/BRIEF.md
# State-Parallel Add-Compare-Select Array with Threshold Normalisation

This block is the recursion core of a maximum-likelihood trellis decoder for a rate 1/2 convolutional code with constraint length 5 and generator polynomials 23 and 35 (octal), which gives a 16-state trellis. On each valid trellis step it takes four branch metrics, one for each two-bit code symbol. Every state gets its own add-compare-select unit, and the units work in parallel. The units are grouped in pairs into butterflies that share the same two predecessor states. Each unit adds the proper branch metric to both candidate predecessor metrics, keeps the larger sum as its new path metric, and reports which predecessor won as one decision bit. The survivor memory that sits downstream consumes these bits.

Path metrics are unsigned and 10 bits wide. They are kept in range by a fixed threshold. When every stored metric has reached the threshold, the threshold is subtracted from every new metric in that same step. No search for the smallest metric is done. A comparator tree runs over the stored metrics and reports the index of the strongest state. Producing the branch metrics and storing the survivors are handled outside this block.

Top module: `acs_array`

## Requirements
- R1: While reset is active, and right after it is released, the stored metric of state 0 is 256 and the metrics of states 1 to 15 are 0. The decision vector is all zeros and the best-state index is 0.
- R2: State s has two predecessors: p0 = 2s mod 16 and p1 = p0 + 1. The input bit is u = s div 8. The branch from predecessor p uses the code symbol {c0,c1}, taken over the window w = u*16 + p, where c0 is the parity of w AND 5'b10011 and c1 is the parity of w AND 5'b11101. Symbol value i takes its branch metric from bm_in[6i+5:6i].
- R3: On a clock edge where in_valid is high, the new metric of each state is the larger of (metric of p0 + its branch metric) and (metric of p1 + its branch metric), less any normalisation amount. The result appears on pm_out after that edge. State s occupies pm_out[10s+9:10s].
- R4: After a valid step, decision bit s is 1 only when the p1 sum is strictly greater than the p0 sum. A tie gives 0, which means the lower-index predecessor.
- R5: If every stored metric is at least 256 when a valid step is taken, 256 is subtracted from every new metric in that step.
- R6: If any stored metric is below 256 when a valid step is taken, nothing is subtracted.
- R7: While in_valid is low, pm_out and dec_out keep their values whatever bm_in carries.
- R8: best_state gives the index of the largest metric currently on pm_out, in the same cycle. On a tie the lowest index wins.
- R9: With branch metrics up to 63, every path metric stays below 768, so no metric ever wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Take one trellis step on this edge |
| bm_in | input | 24 | Four 6-bit branch metrics, indexed by code symbol |
| dec_out | output | 16 | Decision bit per state from the last valid step |
| pm_out | output | 160 | Sixteen 10-bit path metrics |
| best_state | output | 4 | Index of the largest path metric |

## Verification
Path metrics and decisions pass through one register stage. They are due on the first rising edge at which in_valid is sampled high. best_state is combinational from those registers, so it is due in the same cycle as the metrics. The bench drives inputs on a falling edge and checks all three results on the next falling edge, exactly one rising edge later. A reference trellis model in the bench steps at the same point. Reset values are checked one falling edge after reset is asserted or released. Hold behaviour is checked on the falling edge after an edge where in_valid was low.

// File: rtl/acs_pkg.sv
package acs_pkg;

    localparam int NSYM = 4;

    function automatic int unsigned parity32(input int unsigned v);
        int unsigned p;
        p = 0;
        for (int b = 0; b < 32; b++) begin
            p = p ^ ((v >> b) & 1);
        end
        return p;
    endfunction

    function automatic logic [1:0] code_sym(input int unsigned pred, input int unsigned u,
                                            input int k, input int unsigned g0,
                                            input int unsigned g1);
        int unsigned w;
        w = (u << (k - 1)) | pred;
        return {parity32(w & g0) == 1, parity32(w & g1) == 1};
    endfunction

endpackage

// File: rtl/acs_unit.sv
module acs_unit #(
    parameter int PMW    = 10,
    parameter int BMW    = 6,
    parameter int THRESH = 256
) (
    input  logic [PMW-1:0] pm_a,
    input  logic [PMW-1:0] pm_b,
    input  logic [BMW-1:0] bm_a,
    input  logic [BMW-1:0] bm_b,
    input  logic           norm,
    output logic [PMW-1:0] pm_new,
    output logic           dec
);
    localparam logic [PMW-1:0] SUB = PMW'(THRESH);

    logic [PMW-1:0] sum_a;
    logic [PMW-1:0] sum_b;
    logic [PMW-1:0] win;

    always_comb begin
        sum_a  = pm_a + PMW'(bm_a);
        sum_b  = pm_b + PMW'(bm_b);
        dec    = (sum_b > sum_a);
        win    = dec ? sum_b : sum_a;
        pm_new = norm ? (win - SUB) : win;
    end
endmodule

// File: rtl/acs_butterfly.sv
module acs_butterfly #(
    parameter int          K      = 5,
    parameter int          PMW    = 10,
    parameter int          BMW    = 6,
    parameter int          THRESH = 256,
    parameter int unsigned G0     = 5'o23,
    parameter int unsigned G1     = 5'o35,
    parameter int          J      = 0
) (
    input  logic [PMW-1:0]                   pm_lo,
    input  logic [PMW-1:0]                   pm_hi,
    input  logic [acs_pkg::NSYM*BMW-1:0]     bm_all,
    input  logic                             norm,
    output logic [PMW-1:0]                   pm_u0,
    output logic [PMW-1:0]                   pm_u1,
    output logic                             dec_u0,
    output logic                             dec_u1
);
    localparam int unsigned P_LO = 2 * J;
    localparam int unsigned P_HI = 2 * J + 1;

    logic [1:0][PMW-1:0] pm_o;
    logic [1:0]          dec_o;

    generate
        for (genvar u = 0; u < 2; u++) begin : g_u
            localparam logic [1:0] SYM_LO = acs_pkg::code_sym(P_LO, u, K, G0, G1);
            localparam logic [1:0] SYM_HI = acs_pkg::code_sym(P_HI, u, K, G0, G1);
            acs_unit #(.PMW(PMW), .BMW(BMW), .THRESH(THRESH)) u_acs (
                .pm_a  (pm_lo),
                .pm_b  (pm_hi),
                .bm_a  (bm_all[int'(SYM_LO)*BMW +: BMW]),
                .bm_b  (bm_all[int'(SYM_HI)*BMW +: BMW]),
                .norm  (norm),
                .pm_new(pm_o[u]),
                .dec   (dec_o[u])
            );
        end
    endgenerate

    assign pm_u0  = pm_o[0];
    assign pm_u1  = pm_o[1];
    assign dec_u0 = dec_o[0];
    assign dec_u1 = dec_o[1];
endmodule

// File: rtl/acs_best_tree.sv
module acs_best_tree #(
    parameter int NS  = 16,
    parameter int PMW = 10,
    parameter int IW  = $clog2(NS)
) (
    input  logic [NS*PMW-1:0] pm_flat,
    output logic [IW-1:0]     best_idx
);
    localparam int NODES = 2 * NS - 1;

    logic [PMW-1:0] val [NODES];
    logic [IW-1:0]  idx [NODES];

    generate
        for (genvar i = 0; i < NS; i++) begin : g_leaf
            assign val[NS-1+i] = pm_flat[i*PMW +: PMW];
            assign idx[NS-1+i] = IW'(i);
        end
        for (genvar n = 0; n < NS - 1; n++) begin : g_node
            logic take_right;
            assign take_right = val[2*n+2] > val[2*n+1];
            assign val[n] = take_right ? val[2*n+2] : val[2*n+1];
            assign idx[n] = take_right ? idx[2*n+2] : idx[2*n+1];
        end
    endgenerate

    assign best_idx = idx[0];
endmodule

// File: rtl/acs_array.sv
module acs_array #(
    parameter int          K      = 5,
    parameter int          PMW    = 10,
    parameter int          BMW    = 6,
    parameter int          THRESH = 256,
    parameter int unsigned G0     = 5'o23,
    parameter int unsigned G1     = 5'o35,
    localparam int         NS     = 1 << (K - 1),
    localparam int         IW     = K - 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [acs_pkg::NSYM*BMW-1:0]  bm_in,
    output logic [NS-1:0]                 dec_out,
    output logic [NS*PMW-1:0]             pm_out,
    output logic [IW-1:0]                 best_state
);
    localparam int HALF = NS / 2;

    typedef struct packed {
        logic [NS-1:0][PMW-1:0] pm;
        logic [NS-1:0]          dec;
    } acs_state_t;

    function automatic acs_state_t init_state();
        acs_state_t s;
        s        = '0;
        s.pm[0]  = PMW'(THRESH);
        return s;
    endfunction

    acs_state_t             st_d;
    acs_state_t             st_q;
    logic [NS-1:0][PMW-1:0] acs_pm;
    logic [NS-1:0]          acs_dec;
    logic                   norm_d;

    always_comb begin
        norm_d = 1'b1;
        for (int s = 0; s < NS; s++) begin
            if (st_q.pm[s] < PMW'(THRESH)) begin
                norm_d = 1'b0;
            end
        end
    end

    generate
        for (genvar j = 0; j < HALF; j++) begin : g_bfly
            acs_butterfly #(
                .K(K), .PMW(PMW), .BMW(BMW), .THRESH(THRESH),
                .G0(G0), .G1(G1), .J(j)
            ) u_bfly (
                .pm_lo (st_q.pm[2*j]),
                .pm_hi (st_q.pm[2*j+1]),
                .bm_all(bm_in),
                .norm  (norm_d),
                .pm_u0 (acs_pm[j]),
                .pm_u1 (acs_pm[j+HALF]),
                .dec_u0(acs_dec[j]),
                .dec_u1(acs_dec[j+HALF])
            );
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.pm  = acs_pm;
            st_d.dec = acs_dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= init_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign pm_out  = st_q.pm;
    assign dec_out = st_q.dec;

    acs_best_tree #(.NS(NS), .PMW(PMW), .IW(IW)) u_best (
        .pm_flat (st_q.pm),
        .best_idx(best_state)
    );
endmodule

// File: rtl/acs_array_chk.sv
module acs_array_chk #(
    parameter int NS     = 16,
    parameter int PMW    = 10,
    parameter int THRESH = 256,
    parameter int IW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [NS-1:0]     dec_out,
    input logic [NS*PMW-1:0] pm_out,
    input logic [IW-1:0]     best_state
);
    logic [PMW-1:0] cur_max;
    logic           cur_all_ge;
    logic           init_ok;

    always_comb begin
        cur_max    = '0;
        cur_all_ge = 1'b1;
        init_ok    = (pm_out[PMW-1:0] == PMW'(THRESH));
        for (int s = 0; s < NS; s++) begin
            if (pm_out[s*PMW +: PMW] > cur_max) cur_max = pm_out[s*PMW +: PMW];
            if (int'(pm_out[s*PMW +: PMW]) < THRESH) cur_all_ge = 1'b0;
            if (s > 0 && pm_out[s*PMW +: PMW] != '0) init_ok = 1'b0;
        end
    end

    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (init_ok && dec_out == '0 && best_state == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pm_out) && $stable(dec_out)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_max) < 3 * THRESH);

    assert_metric_growth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (int'(cur_max) + ($past(cur_all_ge) ? THRESH : 0) >= int'($past(cur_max))));

    always @(posedge clk) begin
        if (rst_n) begin
            for (int s = 0; s < NS; s++) begin
                assert_best_state_R8: assert (
                    (s < int'(best_state)) ? (pm_out[s*PMW +: PMW] < pm_out[int'(best_state)*PMW +: PMW])
                                           : (pm_out[s*PMW +: PMW] <= pm_out[int'(best_state)*PMW +: PMW]));
            end
        end
    end
endmodule

bind acs_array acs_array_chk #(.NS(NS), .PMW(PMW), .THRESH(THRESH), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dec_out   (dec_out),
    .pm_out    (pm_out),
    .best_state(best_state)
);

// File: tb/tb_acs_array.sv
module tb_acs_array;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 16;
    localparam int PMW = 10;
    localparam int BMW = 6;
    localparam int TH  = 256;
    localparam int NV  = 16;

    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60},
        {1'b1, 6'd63, 6'd0,  6'd0,  6'd63},
        {1'b1, 6'd50, 6'd55, 6'd60, 6'd45},
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60},
        {1'b1, 6'd62, 6'd61, 6'd60, 6'd59},
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60},
        {1'b0, 6'd5,  6'd5,  6'd5,  6'd5},
        {1'b1, 6'd63, 6'd63, 6'd63, 6'd63},
        {1'b1, 6'd40, 6'd50, 6'd60, 6'd63},
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60},
        {1'b1, 6'd0,  6'd63, 6'd63, 6'd0},
        {1'b1, 6'd33, 6'd22, 6'd11, 6'd44},
        {1'b1, 6'd63, 6'd62, 6'd63, 6'd62},
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60},
        {1'b1, 6'd7,  6'd0,  6'd63, 6'd31},
        {1'b1, 6'd60, 6'd60, 6'd60, 6'd60}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [4*BMW-1:0]   bm_in = '0;
    logic [NS-1:0]      dec_out;
    logic [NS*PMW-1:0]  pm_out;
    logic [3:0]         best_state;

    int checks = 0;
    int failures = 0;
    int norm_steps = 0;
    bit done = 0;
    int mpm [NS];
    logic [NS-1:0] mdec;
    string step_tag;
    logic [31:0] rng = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    acs_array dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bm_in(bm_in),
        .dec_out(dec_out), .pm_out(pm_out), .best_state(best_state)
    );

    function automatic int ref_sym(input int p, input int u);
        int w, c0, c1;
        w = u * 16 + p;
        c0 = 0;
        c1 = 0;
        for (int b = 0; b < 5; b++) begin
            if (((5'b10011 >> b) & 1) == 1) c0 = c0 ^ ((w >> b) & 1);
            if (((5'b11101 >> b) & 1) == 1) c1 = c1 ^ ((w >> b) & 1);
        end
        return c0 * 2 + c1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) mpm[s] = (s == 0) ? TH : 0;
        mdec = '0;
    endtask

    task automatic model_step(input bit v, input logic [4*BMW-1:0] bm);
        int np [NS];
        logic [NS-1:0] nd;
        bit nrm;
        if (!v) begin
            step_tag = "R7";
            return;
        end
        nrm = 1;
        for (int s = 0; s < NS; s++) if (mpm[s] < TH) nrm = 0;
        step_tag = nrm ? "R5 R2 R3" : "R6 R2 R3";
        if (nrm) norm_steps++;
        for (int s = 0; s < NS; s++) begin
            int p0, u, a, b, m;
            p0 = (2 * s) % NS;
            u  = s / 8;
            a  = mpm[p0]   + int'(bm[ref_sym(p0, u) * BMW +: BMW]);
            b  = mpm[p0+1] + int'(bm[ref_sym(p0 + 1, u) * BMW +: BMW]);
            nd[s] = (b > a);
            m = (b > a) ? b : a;
            np[s] = nrm ? m - TH : m;
        end
        for (int s = 0; s < NS; s++) mpm[s] = np[s];
        mdec = nd;
    endtask

    task automatic check_state(input string tag);
        logic [NS*PMW-1:0] exp_pm;
        int eb;
        eb = 0;
        for (int s = 0; s < NS; s++) begin
            exp_pm[s*PMW +: PMW] = PMW'(mpm[s]);
            if (mpm[s] > mpm[eb]) eb = s;
        end
        checks++;
        if (pm_out !== exp_pm) begin
            failures++;
            $display("FAIL %s metrics actual=%h expected=%h", tag, pm_out, exp_pm);
        end
        checks++;
        if (dec_out !== mdec) begin
            failures++;
            $display("FAIL R4 (%s) decisions actual=%h expected=%h", tag, dec_out, mdec);
        end
        checks++;
        if (best_state !== 4'(eb)) begin
            failures++;
            $display("FAIL R8 (%s) best actual=%0d expected=%0d", tag, best_state, eb);
        end
    endtask

    task automatic apply(input bit v, input logic [4*BMW-1:0] bm);
        in_valid = v;
        bm_in    = bm;
        @(negedge clk);
        model_step(v, bm);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        model_reset();
        check_state("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after release");
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        model_reset();
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R4 R8: tie from reset, equal metrics everywhere
        apply(1'b1, {6'd20, 6'd20, 6'd20, 6'd20});
        check_state("R4 R8 tie step");
        checks++;
        if (pm_out[8*PMW +: PMW] !== 10'd276 || dec_out !== '0 || best_state !== 4'd0) begin
            failures++;
            $display("FAIL R4 tie actual pm8=%0d dec=%h best=%0d expected pm8=276 dec=0 best=0",
                     pm_out[8*PMW +: PMW], dec_out, best_state);
        end

        do_reset();
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][24], VEC[i][23:0]);
            check_state(step_tag);
        end

        // R7: valid low with busy branch metrics
        apply(1'b0, {6'd63, 6'd1, 6'd63, 6'd1});
        check_state("R7 hold");

        for (int i = 0; i < 3000; i++) begin
            bit v;
            logic [23:0] bm;
            rng = next_rng(rng);
            v   = (rng[31:29] != 3'd0);
            bm  = rng[23:0];
            apply(v, bm);
            check_state(step_tag);
            checks++;
            for (int s = 0; s < NS; s++) begin
                if (int'(pm_out[s*PMW +: PMW]) >= 3 * TH) begin
                    failures++;
                    $display("FAIL R9 state %0d actual=%0d expected below %0d",
                             s, pm_out[s*PMW +: PMW], 3 * TH);
                    break;
                end
            end
        end

        checks++;
        if (norm_steps == 0) begin
            failures++;
            $display("FAIL R5 normalisation steps actual=0 expected>0");
        end

        // R1: reset in mid-run
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule